// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a purely combinational 32-bit integer arithmetic-logic unit for a datapath execute stage. Two operands and a 4-bit operation code enter. One result word and three status bits leave in the same cycle: zero, equal and signed overflow. The block holds no state, so a surrounding pipeline registers its outputs wherever it needs them.

Each operation has its own subcircuit, and all of them run in parallel:

- a ripple-carry adder that also subtracts by inverting the second operand and setting the carry-in;
- a signed set-less-than stage fed by that adder;
- a logarithmic barrel shifter that handles left, logical-right and arithmetic-right shifts;
- the four bitwise logic functions.

A 16-input result multiplexer, steered by the operation code, picks one of these outputs. Codes that carry no operation return zero.

The flags come from separate logic:

- Equal is a direct bitwise comparison of the two operands.
- Zero looks at the final selected result.
- Overflow is taken from the adder and is passed on only for add and subtract.

Top module: `int_alu`

## Requirements
- R1: Operation code 0000 (add) returns (A + B) modulo 2^32.
- R2: Operation code 0001 (subtract) returns (A - B) modulo 2^32, computed as A + ~B + 1.
- R3: The overflow output is 1 when add or subtract overflows in two's-complement arithmetic. This happens when the sign of A and the sign of the effective second operand (B for add, ~B for subtract) agree and the result sign differs from them. For every other code the overflow output is 0.
- R4: Codes 0010, 0011, 0100 and 0101 return A AND B, A OR B, A XOR B and NOT(A OR B), respectively.
- R5: Code 0110 (signed set-less-than) returns 1 in bit 0 when A < B as signed values, and 0 otherwise. The answer is correct even when A - B overflows. Bits 31 to 1 are always 0.
- R6: Code 0111 shifts A left and code 1000 shifts A right logically. The shift amount is B[4:0], the upper bits of B are ignored, and vacated bits are filled with 0.
- R7: Code 1001 shifts A right arithmetically by B[4:0], filling vacated bits with A[31].
- R8: Codes 1010 through 1111 return a result of 0.
- R9: The zero output is 1 exactly when the selected result is all zeros, for every operation code, including shifts, set-less-than and unused codes.
- R10: The equal output is 1 exactly when A equals B, whatever the operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand A |
| opb_i | input | 32 | Second operand B; B[4:0] is the shift amount for shifts |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | Result is all zeros |
| equal_o | output | 1 | A equals B |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
Several flags can be raised in the same cycle, and that combination is the main target of the directed tests:

- **Overflow with zero.** Adding 0x80000000 to itself overflows and also produces a zero result, so both flags must be set together.
- **Equal, zero and a clear overflow.** Subtracting an operand from itself raises equal and zero at once while overflow stays low.
- **Set-less-than under overflow.** The comparison of 0x80000000 with 1 and of 0x7FFFFFFF with -1 overflows inside the subtractor. The 0/1 answer must still be correct, and the overflow port must stay clear for this operation code.

A scoreboard computes the expected word and all three flags from arithmetic on the operands. It compares every field of each response, for the directed cases and for a batch of random operations across all sixteen codes.

// File: rtl/alu_pkg.sv
// Package: shared widths and encodings for the integer ALU.
// Assumes: operation codes are 4 bits; unused codes are decoded by the top.
package alu_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'b0000,
        OP_SUB  = 4'b0001,
        OP_AND  = 4'b0010,
        OP_OR   = 4'b0011,
        OP_XOR  = 4'b0100,
        OP_NOR  = 4'b0101,
        OP_SLT  = 4'b0110,
        OP_SLL  = 4'b0111,
        OP_SRL  = 4'b1000,
        OP_SRA  = 4'b1001
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT      = 2'd0,
        SH_RIGHT_LOG = 2'd1,
        SH_RIGHT_ARI = 2'd2
    } shift_mode_e;
endpackage

// File: rtl/alu_adder.sv
// Module: ripple-carry adder/subtractor with signed overflow detection.
// Subtraction inverts b and injects a carry-in of one (a + ~b + 1).
// Assumes: W >= 2; outputs are combinational.
module alu_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   carry;

    // Conditionally invert the second operand for subtraction.
    assign b_eff    = b ^ {W{sub}};
    assign carry[0] = sub;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_fa
            // One full-adder cell per bit.
            assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
        end
    endgenerate

    // Signed overflow: operand signs agree, result sign differs.
    assign ovf = (a[W-1] ~^ b_eff[W-1]) & (sum[W-1] ^ a[W-1]);

    // Guard: a minus itself is zero with no overflow.
    always_comb begin
        // R2
        sub_self_chk: assert (!(sub && (a == b)) || ((sum == '0) && !ovf))
            else $error("subtracting equal operands gave %h ovf=%b", sum, ovf);
        // R3
        add_mixed_sign_chk: assert (!(!sub && (a[W-1] != b[W-1])) || !ovf)
            else $error("add of mixed-sign operands flagged overflow");
    end
endmodule

// File: rtl/alu_slt.sv
// Module: signed set-less-than from a subtraction result.
// Assumes: diff_msb and ovf come from a - b; their XOR is the true sign.
module alu_slt #(
    parameter int unsigned W = 32
) (
    input  logic         diff_msb,
    input  logic         ovf,
    output logic [W-1:0] res
);
    // Correct the sign of the difference when the subtraction wrapped.
    assign res = {{(W-1){1'b0}}, diff_msb ^ ovf};
endmodule

// File: rtl/alu_shifter.sv
// Module: logarithmic barrel shifter with left, logical-right and
// arithmetic-right modes. Left shifts reuse the right-shift stages by
// bit-reversing the data on the way in and out.
// Assumes: W is a power of two; shamt has $clog2(W) bits.
module alu_shifter
    import alu_pkg::*;
#(
    parameter int unsigned W   = 32,
    localparam int unsigned SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] shamt,
    input  shift_mode_e    mode,
    output logic [W-1:0]   dout
);
    logic [W-1:0]       rev_in;
    logic [W-1:0]       rev_out;
    logic [SHW:0][W-1:0] stage;
    logic               fill;
    logic               left;

    // Mode decode: direction and the bit shifted into vacated positions.
    assign left = (mode == SH_LEFT);
    assign fill = (mode == SH_RIGHT_ARI) ? din[W-1] : 1'b0;

    genvar i, k;
    generate
        for (i = 0; i < W; i++) begin : g_rev
            // Bit reversal so one right-shift network serves both directions.
            assign rev_in[i]  = din[W-1-i];
            assign rev_out[i] = stage[SHW][W-1-i];
        end
        for (k = 0; k < SHW; k++) begin : g_stage
            localparam int unsigned S = 1 << k;
            // Stage k shifts right by 2^k when its amount bit is set.
            assign stage[k+1] = shamt[k] ? {{S{fill}}, stage[k][W-1:S]} : stage[k];
        end
    endgenerate

    assign stage[0] = left ? rev_in : din;
    assign dout     = left ? rev_out : stage[SHW];

    // Guard: a zero shift amount passes the data through unchanged.
    always_comb begin
        // R6
        zero_shift_chk: assert (!(shamt == '0) || (dout == din))
            else $error("zero shift altered data");
    end
endmodule

// File: rtl/alu_mux16.sv
// Module: 16-input result multiplexer.
// Assumes: every input lane is driven; sel picks one lane.
module alu_mux16 #(
    parameter int unsigned W = 32,
    parameter int unsigned N = 16,
    localparam int unsigned SELW = $clog2(N)
) (
    input  logic [N-1:0][W-1:0] lanes,
    input  logic [SELW-1:0]     sel,
    output logic [W-1:0]        y
);
    // Select the lane addressed by sel.
    assign y = lanes[sel];
endmodule

// File: rtl/int_alu.sv
// Module: combinational 32-bit integer ALU, top level.
// Runs adder/subtractor, set-less-than, barrel shifter and logic functions
// in parallel and picks one through a 16-input multiplexer. Zero is taken
// on the selected result, equal on the operands, overflow from the adder
// for add and subtract only.
// Assumes: no clock or reset; outputs settle combinationally.
module int_alu
    import alu_pkg::*;
#(
    parameter int unsigned W      = DATA_W,
    parameter int unsigned NLANES = 1 << OP_W,
    localparam int unsigned SHW   = $clog2(W)
) (
    input  logic [W-1:0]    opa_i,
    input  logic [W-1:0]    opb_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    result_o,
    output logic            zero_o,
    output logic            equal_o,
    output logic            ovf_o
);
    logic [W-1:0]             sum;
    logic                     add_ovf;
    logic                     sub_mode;
    logic                     arith_op;
    logic [W-1:0]             slt_res;
    logic [W-1:0]             shift_res;
    shift_mode_e              sh_mode;
    logic [NLANES-1:0][W-1:0] lanes;

    // Subtractor mode for SUB and for the comparison behind SLT.
    assign sub_mode = (op_i == OP_SUB) || (op_i == OP_SLT);
    assign arith_op = (op_i == OP_ADD) || (op_i == OP_SUB);

    alu_adder #(.W(W)) u_adder (
        .a   (opa_i),
        .b   (opb_i),
        .sub (sub_mode),
        .sum (sum),
        .ovf (add_ovf)
    );

    alu_slt #(.W(W)) u_slt (
        .diff_msb (sum[W-1]),
        .ovf      (add_ovf),
        .res      (slt_res)
    );

    // Shifter mode from the operation code.
    always_comb begin
        unique case (op_i)
            OP_SLL:  sh_mode = SH_LEFT;
            OP_SRA:  sh_mode = SH_RIGHT_ARI;
            default: sh_mode = SH_RIGHT_LOG;
        endcase
    end

    alu_shifter #(.W(W)) u_shift (
        .din   (opa_i),
        .shamt (opb_i[SHW-1:0]),
        .mode  (sh_mode),
        .dout  (shift_res)
    );

    // Fill the multiplexer lanes; unused codes stay zero.
    always_comb begin
        lanes                     = '0;
        lanes[OP_ADD]             = sum;
        lanes[OP_SUB]             = sum;
        lanes[OP_AND]             = opa_i & opb_i;
        lanes[OP_OR]              = opa_i | opb_i;
        lanes[OP_XOR]             = opa_i ^ opb_i;
        lanes[OP_NOR]             = ~(opa_i | opb_i);
        lanes[OP_SLT]             = slt_res;
        lanes[OP_SLL]             = shift_res;
        lanes[OP_SRL]             = shift_res;
        lanes[OP_SRA]             = shift_res;
    end

    alu_mux16 #(.W(W), .N(NLANES)) u_mux (
        .lanes (lanes),
        .sel   (op_i),
        .y     (result_o)
    );

    // Status flags.
    assign zero_o  = ~|result_o;
    assign equal_o = ~|(opa_i ^ opb_i);
    assign ovf_o   = add_ovf & arith_op;

    // Cross-checks between independently built pieces.
    always_comb begin
        // R10
        eq_vs_sub_chk: assert (!(op_i == OP_SUB) || (equal_o == zero_o))
            else $error("equal and zero disagree on subtract");
        // R3
        add_ovf_sign_chk: assert (!(ovf_o && (op_i == OP_ADD)) || (opa_i[W-1] == opb_i[W-1]))
            else $error("add overflow with mixed-sign operands");
        // R5
        slt_upper_chk: assert (!(op_i == OP_SLT) || (result_o[W-1:1] == '0))
            else $error("set-less-than upper bits not clear");
        // R8
        unused_code_chk: assert (!(op_i > OP_SRA) || (zero_o && (result_o == '0)))
            else $error("unused code returned nonzero");
    end
endmodule

// File: tb/tb_int_alu.sv
// Scoreboard bench: the driver pushes expected items, the monitor compares.
module tb_int_alu;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] res;
        logic         z;
        logic         e;
        logic         v;
        logic [3:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [3:0]   op = '0;
    logic [W-1:0] result;
    logic         zero, equal, ovf;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 1'b0;
    exp_t         sb[$];

    always #2.5 clk = ~clk;

    int_alu dut (
        .opa_i(opa), .opb_i(opb), .op_i(op),
        .result_o(result), .zero_o(zero), .equal_o(equal), .ovf_o(ovf)
    );

    function automatic exp_t model(input logic [3:0] o, input logic [W-1:0] a,
                                   input logic [W-1:0] b, input string tag);
        exp_t x;
        x.op = o; x.a = a; x.b = b; x.tag = tag; x.v = 1'b0;
        case (o)
            4'd0: begin x.res = a + b; x.v = (a[31] == b[31]) && (x.res[31] != a[31]); end
            4'd1: begin x.res = a - b; x.v = (a[31] != b[31]) && (x.res[31] != a[31]); end
            4'd2: x.res = a & b;
            4'd3: x.res = a | b;
            4'd4: x.res = a ^ b;
            4'd5: x.res = ~(a | b);
            4'd6: x.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd7: x.res = a << b[4:0];
            4'd8: x.res = a >> b[4:0];
            4'd9: x.res = $unsigned($signed(a) >>> b[4:0]);
            default: x.res = '0;
        endcase
        x.z = (x.res == '0);
        x.e = (a == b);
        return x;
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4, 4'd5: return "R4";
            4'd6: return "R5";
            4'd7, 4'd8: return "R6";
            4'd9: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Driver: apply one operation per cycle and push its expectation.
    task automatic drive(input logic [3:0] o, input logic [W-1:0] a,
                         input logic [W-1:0] b, input string tag);
        @(posedge clk);
        op = o; opa = a; opb = b;
        sb.push_back(model(o, a, b, tag));
    endtask

    // Monitor: at each falling edge compare the pending expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && sb.size() != 0) begin
                exp_t x;
                x = sb.pop_front();
                n_cmp++;
                if (result !== x.res || zero !== x.z || equal !== x.e || ovf !== x.v) begin
                    n_bad++;
                    $display("FAIL %s (R9 zero, R10 equal, R3 ovf) op=%h a=%h b=%h: got res=%h z=%b e=%b v=%b, expected res=%h z=%b e=%b v=%b",
                             x.tag, x.op, x.a, x.b, result, zero, equal, ovf, x.res, x.z, x.e, x.v);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero inputs give zero result, zero and equal set (R9, R10).
        drive(4'd0, 32'h0, 32'h0, "R9 reset-state");
        // R1 add
        drive(4'd0, 32'h1234_5678, 32'h1111_1111, "R1 add");
        drive(4'd0, 32'h7FFF_FFFF, 32'h1, "R3 add overflow");
        drive(4'd0, 32'hFFFF_FFFF, 32'h1, "R9 add wraps to zero no ovf");
        drive(4'd0, 32'h8000_0000, 32'h8000_0000, "R3 R9 overflow with zero");
        // R2 subtract
        drive(4'd1, 32'h0000_0010, 32'h0000_0020, "R2 sub negative");
        drive(4'd1, 32'h8000_0000, 32'h1, "R3 sub overflow");
        drive(4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R10 sub equal zero");
        // R4 logic
        drive(4'd2, 32'hF0F0_FF00, 32'hFF00_F0F0, "R4 and");
        drive(4'd3, 32'hF0F0_0000, 32'h0000_0F0F, "R4 or");
        drive(4'd4, 32'hAAAA_5555, 32'hAAAA_5555, "R4 R10 xor equal");
        drive(4'd5, 32'hFFFF_0000, 32'h0000_FFFF, "R4 R9 nor zero");
        drive(4'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R3 no ovf on logic");
        // R5 set-less-than
        drive(4'd6, 32'hFFFF_FFFF, 32'h1, "R5 neg lt pos");
        drive(4'd6, 32'h8000_0000, 32'h1, "R5 overflowing compare");
        drive(4'd6, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5 R9 overflowing compare false");
        drive(4'd6, 32'h5, 32'h5, "R5 R10 equal not less");
        // R6 shifts
        drive(4'd7, 32'h0000_00F1, 32'h4, "R6 sll");
        drive(4'd7, 32'h0000_0003, 32'h1F, "R6 sll by 31");
        drive(4'd8, 32'hF000_0000, 32'hFFFF_FFE4, "R6 srl upper B ignored");
        drive(4'd8, 32'h8000_0000, 32'h0, "R6 srl zero amount");
        // R7 arithmetic shift
        drive(4'd9, 32'h8000_0F00, 32'h25, "R7 sra negative");
        drive(4'd9, 32'h4000_0000, 32'h1E, "R7 sra positive");
        drive(4'd9, 32'hFFFF_FFFF, 32'h1F, "R7 sra all ones");
        // R8 unused codes
        for (int c = 10; c < 16; c++)
            drive(c[3:0], 32'hFFFF_FFFF, 32'h1234_5678, "R8 unused code");
        drive(4'd15, 32'h77, 32'h77, "R8 R10 unused equal");
        // Random mix across all codes
        for (int i = 0; i < 400; i++) begin
            logic [3:0]   o;
            logic [W-1:0] a, b;
            o = 4'($urandom_range(0, 15));
            a = $urandom();
            b = (i % 7 == 0) ? a : $urandom();
            drive(o, a, b, tag_of(o));
        end
        repeat (3) @(posedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard R9 leftover items: got %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule